// File: doc/BRIEF.md
# Serial Management Responder

This block is the device-side end of a two-wire serial management link. A controller drives a clock line and a bidirectional data line. The responder samples the data line on every rising clock edge and finds the start of a frame. It then decodes the operation, the device address and the register address. A write frame updates a small internal bank of 16-bit registers. A read frame makes the responder drive the register contents back through a pad with an output enable.

The device address comes from three strap inputs. Thirteen registers are implemented at register addresses 0 through 12. When a read finishes, the block pulses a strobe together with the register address. Registers whose reads have side effects can use this pulse.

Top module: `mgmt_serial_responder`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones have been sampled, followed by the start pair 0 then 1. A frame with 31 leading ones is ignored, and a frame with 40 leading ones is accepted.
- R2: The two opcode bits that follow the start pair select read for 1 then 0 and write for 0 then 1. The patterns 0 0 and 1 1 cause the frame to be ignored.
- R3: The 5-bit device address is sent MSB first. It matches only when its two upper bits are 0 and its three lower bits equal a non-zero strap value. A non-matching frame is ignored, and a strap of 0 never matches.
- R4: On a matching read, the output enable is low during the first turnaround bit. It drives 0 during the second turnaround bit. It then drives the 16 data bits MSB first, each one valid at the rising edge that samples it, so the enable stays high for exactly 17 bit times.
- R5: A matching write takes the 16 data bits, MSB first, that follow the two turnaround bits. It stores them in the addressed register, and a later read returns that value.
- R6: The output enable is low at all times other than the 17-bit window of a matching read, and it is low again by the sample edge after the last data bit.
- R7: Register addresses 13 to 31 read as 0x0000. Writes to them change no implemented register.
- R8: After a frame is rejected, no new frame is accepted until a fresh run of at least 32 ones has been seen. A frame sent directly after a rejected one without its own preamble is ignored.
- R9: A completed matching read raises the strobe for exactly one cycle, in the cycle after the last data bit is sampled, with the register address on the address output. A write raises no strobe.
- R10: After reset, the output enable and the strobe are low, and every implemented register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock. All state changes on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_addr | input | 3 | Strapped device address, valid 1 to 7 |
| mdio_i | input | 1 | Sampled level of the data pad |
| mdio_o | output | 1 | Value driven onto the data pad |
| mdio_oe | output | 1 | Output enable of the data pad |
| rd_stb | output | 1 | One-cycle pulse when a read completes |
| rd_addr | output | 5 | Register address of the completed read |

## Verification
On every cycle, the embedded assertions check four things:
- The output enable rises only where the decoder starts a read, and it opens by driving 0.
- The enable falls in the same edge that raises the strobe, and the strobe lasts one cycle.
- The strap is non-zero whenever the pad is driven.
- A write to an unimplemented address leaves the register bank unchanged.

Other behaviour can only be shown by the directed scenarios:
- the data values that are read back;
- the MSB-first bit order;
- the count of preamble ones needed for a frame to be accepted;
- the rejection of bad opcodes and foreign addresses;
- the re-synchronization after a rejected frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

   typedef enum logic [2:0] {
      FS_HUNT,
      FS_START,
      FS_OPCODE,
      FS_DEVADDR,
      FS_REGADDR,
      FS_TURN,
      FS_DATA
   } frame_state_t;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_frame_decoder.sv
module mgmt_frame_decoder
   import mgmt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int DEV_W    = 5,
   parameter int STRAP_W  = 3,
   parameter int PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic [STRAP_W-1:0] strap,
   output logic              tx_start,
   output logic              wr_en,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_stb
);

   localparam int CNT_W  = $clog2(DATA_W);
   localparam int ONES_W = $clog2(PRE_LEN + 1);

   frame_state_t            state;
   logic [ONES_W-1:0]       ones;
   logic [CNT_W-1:0]        bcnt;
   logic [DATA_W-2:0]       fld;
   logic                    is_rd;
   logic [1:0]              opc_now;
   logic [DEV_W-1:0]        dev_now;
   logic                    dev_hit;

   assign opc_now = {fld[0], bit_in};
   assign dev_now = {fld[DEV_W-2:0], bit_in};
   assign dev_hit = (dev_now[DEV_W-1:STRAP_W] == '0) &&
                    (dev_now[STRAP_W-1:0] == strap) && (strap != '0);

   assign tx_start = (state == FS_TURN) && (bcnt == '0) && is_rd;
   assign wr_en    = (state == FS_DATA) && (bcnt == CNT_W'(DATA_W-1)) && !is_rd;
   assign wr_data  = {fld, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_HUNT;
         ones     <= '0;
         bcnt     <= '0;
         fld      <= '0;
         is_rd    <= 1'b0;
         reg_addr <= '0;
         rd_stb   <= 1'b0;
      end else begin
         rd_stb <= 1'b0;
         if (state != FS_HUNT) begin
            fld <= {fld[DATA_W-3:0], bit_in};
         end
         case (state)
            FS_HUNT: begin
               if (bit_in) begin
                  if (ones != ONES_W'(PRE_LEN)) ones <= ones + 1'b1;
               end else if (ones == ONES_W'(PRE_LEN)) begin
                  state <= FS_START;
               end else begin
                  ones <= '0;
               end
            end
            FS_START: begin
               ones <= '0;
               bcnt <= '0;
               state <= bit_in ? FS_OPCODE : FS_HUNT;
            end
            FS_OPCODE: begin
               if (bcnt == CNT_W'(1)) begin
                  bcnt <= '0;
                  if (opc_now == OPC_READ) begin
                     is_rd <= 1'b1;
                     state <= FS_DEVADDR;
                  end else if (opc_now == OPC_WRITE) begin
                     is_rd <= 1'b0;
                     state <= FS_DEVADDR;
                  end else begin
                     state <= FS_HUNT;
                  end
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            FS_DEVADDR: begin
               if (bcnt == CNT_W'(DEV_W-1)) begin
                  bcnt  <= '0;
                  state <= dev_hit ? FS_REGADDR : FS_HUNT;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            FS_REGADDR: begin
               if (bcnt == CNT_W'(ADDR_W-1)) begin
                  bcnt     <= '0;
                  reg_addr <= {fld[ADDR_W-2:0], bit_in};
                  state    <= FS_TURN;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            FS_TURN: begin
               if (bcnt == CNT_W'(1)) begin
                  bcnt  <= '0;
                  state <= FS_DATA;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            FS_DATA: begin
               if (bcnt == CNT_W'(DATA_W-1)) begin
                  bcnt   <= '0;
                  state  <= FS_HUNT;
                  rd_stb <= is_rd;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: state <= FS_HUNT;
         endcase
      end
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb); // R9

endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int NUM_REGS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int FULL_MAP = (NUM_REGS == (1 << ADDR_W)) ? 1 : 0;

   logic [DATA_W-1:0]          regs_q [NUM_REGS];
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
            regs_q[i] <= wr_data;
         end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
   end

   if (FULL_MAP == 1) begin : g_full_map
      assign rd_data = regs_q[rd_addr];
   end else begin : g_partial_map
      always_comb begin
         rd_data = '0;
         for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_data = regs_q[k];
         end
      end

      AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(regs_flat)); // R7
   end

endmodule

// File: rtl/mgmt_pad_driver.sv
module mgmt_pad_driver #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_data,
   output logic              pad_o,
   output logic              pad_oe
);

   localparam int SPAN_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] shreg;
   logic [SPAN_W-1:0] sent;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         sent   <= '0;
         pad_o  <= 1'b0;
         pad_oe <= 1'b0;
      end else if (start && !pad_oe) begin
         shreg  <= load_data;
         sent   <= '0;
         pad_o  <= 1'b0;
         pad_oe <= 1'b1;
      end else if (pad_oe) begin
         if (sent == SPAN_W'(DATA_W)) begin
            pad_oe <= 1'b0;
            pad_o  <= 1'b0;
         end else begin
            pad_o <= shreg[DATA_W-1];
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            sent  <= sent + 1'b1;
         end
      end
   end

   AST_TURN_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_oe) |-> !pad_o); // R4

endmodule

// File: rtl/mgmt_serial_responder.sv
module mgmt_serial_responder #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int DEV_W    = 5,
   parameter int STRAP_W  = 3,
   parameter int NUM_REGS = 13,
   parameter int PRE_LEN  = 32
) (
   input  logic               mdc,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               mdio_i,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               rd_stb,
   output logic [ADDR_W-1:0]  rd_addr
);

   if (DEV_W <= STRAP_W) begin : g_chk_dev
      $error("device address must be wider than the strap");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_chk_regs
      $error("register count does not fit the register address");
   end
   if (DATA_W < 4 || DATA_W < DEV_W || DATA_W < ADDR_W) begin : g_chk_data
      $error("data field too narrow for the bit counter");
   end
   if (PRE_LEN < 1) begin : g_chk_pre
      $error("preamble length must be positive");
   end

   logic              tx_start;
   logic              wr_en;
   logic [ADDR_W-1:0] reg_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;

   mgmt_frame_decoder #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .DEV_W  (DEV_W),
      .STRAP_W(STRAP_W),
      .PRE_LEN(PRE_LEN)
   ) u_decoder (
      .clk     (mdc),
      .rst_n   (rst_n),
      .bit_in  (mdio_i),
      .strap   (strap_addr),
      .tx_start(tx_start),
      .wr_en   (wr_en),
      .reg_addr(reg_addr),
      .wr_data (wr_data),
      .rd_stb  (rd_stb)
   );

   mgmt_reg_bank #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .NUM_REGS(NUM_REGS)
   ) u_bank (
      .clk    (mdc),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(reg_addr),
      .wr_data(wr_data),
      .rd_addr(reg_addr),
      .rd_data(rd_data)
   );

   mgmt_pad_driver #(
      .DATA_W(DATA_W)
   ) u_pad (
      .clk      (mdc),
      .rst_n    (rst_n),
      .start    (tx_start),
      .load_data(rd_data),
      .pad_o    (mdio_o),
      .pad_oe   (mdio_oe)
   );

   assign rd_addr = reg_addr;

   AST_OE_FROM_READ: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> $past(tx_start)); // R6

   AST_STB_ENDS_READ: assert property (@(posedge mdc) disable iff (!rst_n)
      rd_stb |-> $fell(mdio_oe)); // R9

   AST_OE_NEEDS_STRAP: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> (strap_addr != '0)); // R3

endmodule

// File: tb/mgmt_serial_responder_test.sv
module mgmt_serial_responder_test;

   logic       mdc = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'd5;
   logic       mst_en = 1'b0;
   logic       mst_bit = 1'b1;
   logic       mdio_o, mdio_oe, rd_stb;
   logic [4:0] rd_addr;
   logic       line;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   int oe_cyc   = 0;
   int stb_cyc  = 0;
   logic [4:0] stb_addr = '0;

   logic ta1_oe, ta2_oe, ta2_val, end_oe, end_stb;

   always #10 mdc = ~mdc;

   assign line = mdio_oe ? mdio_o : (mst_en ? mst_bit : 1'b1);

   mgmt_serial_responder uut (
      .mdc       (mdc),
      .rst_n     (rst_n),
      .strap_addr(strap),
      .mdio_i    (line),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rd_stb    (rd_stb),
      .rd_addr   (rd_addr)
   );

   always @(negedge mdc) begin
      cycles = cycles + 1;
      if (mdio_oe) oe_cyc = oe_cyc + 1;
      if (rd_stb) begin
         stb_cyc  = stb_cyc + 1;
         stb_addr = rd_addr;
      end
      if (cycles > 150000) begin
         n_checks = n_checks + 1;
         n_fail   = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b);
      mst_en  = 1'b1;
      mst_bit = b;
      @(posedge mdc);
      @(negedge mdc);
   endtask

   task automatic send_field(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
   endtask

   task automatic send_ones(input int n);
      for (int i = 0; i < n; i++) clk_bit(1'b1);
   endtask

   task automatic idle(input int n);
      mst_en = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(posedge mdc);
         @(negedge mdc);
      end
   endtask

   task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] dev, input logic [4:0] ra,
                        input logic [15:0] wdat, output logic [15:0] rdat);
      rdat = '0;
      send_ones(pre);
      send_field({14'd0, st}, 2);
      send_field({14'd0, op}, 2);
      send_field({11'd0, dev}, 5);
      send_field({11'd0, ra}, 5);
      if (op == 2'b10) begin
         mst_en = 1'b0;
         ta1_oe = mdio_oe;
         @(posedge mdc); @(negedge mdc);
         ta2_oe  = mdio_oe;
         ta2_val = line;
         for (int i = 15; i >= 0; i--) begin
            @(posedge mdc); @(negedge mdc);
            rdat[i] = line;
         end
         @(posedge mdc); @(negedge mdc);
         end_oe  = mdio_oe;
         end_stb = rd_stb;
         idle(2);
      end else begin
         send_field(16'h0002, 2);
         send_field(wdat, 16);
         idle(2);
      end
   endtask

   task automatic do_write(input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] d);
      logic [15:0] dummy;
      frame(32, 2'b01, 2'b01, dev, ra, d, dummy);
   endtask

   task automatic do_read(input logic [4:0] dev, input logic [4:0] ra, output logic [15:0] d);
      frame(32, 2'b01, 2'b10, dev, ra, 16'h0, d);
   endtask

   // full protocol check of one matching read
   task automatic expect_read(input string req, input logic [4:0] ra, input logic [15:0] exp);
      logic [15:0] d;
      int oe0, stb0;
      oe0 = oe_cyc; stb0 = stb_cyc;
      do_read({2'b00, strap}, ra, d);
      check(req, d, exp);
      check("R4 turnaround bit1 floats", {15'd0, ta1_oe}, 16'd0);
      check("R4 turnaround bit2 driven 0", {14'd0, ta2_oe, ta2_val}, 16'h0002);
      check("R4 R6 enable span 17", 16'(oe_cyc - oe0), 16'd17);
      check("R6 released after frame", {15'd0, end_oe}, 16'd0);
      check("R9 strobe after read", {15'd0, end_stb}, 16'd1);
      check("R9 strobe one cycle", 16'(stb_cyc - stb0), 16'd1);
      check("R9 strobe address", {11'd0, stb_addr}, {11'd0, ra});
   endtask

   // frame that must draw no response at all
   task automatic expect_silent(input string req, input int pre, input logic [1:0] st,
                                input logic [1:0] op, input logic [4:0] dev, input logic [4:0] ra,
                                input logic [15:0] wdat);
      logic [15:0] d;
      int oe0, stb0;
      oe0 = oe_cyc; stb0 = stb_cyc;
      frame(pre, st, op, dev, ra, wdat, d);
      check(req, 16'(oe_cyc - oe0), 16'd0);
      check(req, 16'(stb_cyc - stb0), 16'd0);
   endtask

   task automatic t_reset;
      check("R10 enable low in reset", {15'd0, mdio_oe}, 16'd0);
      check("R10 strobe low in reset", {15'd0, rd_stb}, 16'd0);
      @(negedge mdc);
      rst_n = 1'b1;
      idle(2);
      for (int r = 0; r < 13; r++) expect_read("R10 register resets to 0", 5'(r), 16'h0000);
   endtask

   task automatic t_write_read;
      int stb0;
      stb0 = stb_cyc;
      do_write({2'b00, strap}, 5'd3, 16'hA5C3);
      check("R9 no strobe on write", 16'(stb_cyc - stb0), 16'd0);
      expect_read("R5 R4 readback reg3", 5'd3, 16'hA5C3);
      do_write({2'b00, strap}, 5'd0, 16'h7FFE);
      expect_read("R5 readback reg0", 5'd0, 16'h7FFE);
      expect_read("R5 reg3 kept", 5'd3, 16'hA5C3);
   endtask

   task automatic t_boundary;
      do_write({2'b00, strap}, 5'd12, 16'h8001);
      expect_read("R5 last register", 5'd12, 16'h8001);
      do_write({2'b00, strap}, 5'd13, 16'hFFFF);
      expect_read("R7 unmapped reads zero", 5'd13, 16'h0000);
      do_write({2'b00, strap}, 5'd31, 16'h1234);
      expect_read("R7 unmapped 31 reads zero", 5'd31, 16'h0000);
      expect_read("R7 reg12 untouched", 5'd12, 16'h8001);
      expect_read("R7 reg0 untouched", 5'd0, 16'h7FFE);
   endtask

   task automatic t_address;
      expect_silent("R3 wrong device address", 32, 2'b01, 2'b10, 5'd6, 5'd3, 16'h0);
      expect_silent("R3 upper bits set", 32, 2'b01, 2'b10, 5'h0D, 5'd3, 16'h0);
      expect_silent("R3 foreign write", 32, 2'b01, 2'b01, 5'd4, 5'd3, 16'h1111);
      expect_read("R3 foreign write ignored", 5'd3, 16'hA5C3);
      strap = 3'd0;
      expect_silent("R3 zero strap never matches", 32, 2'b01, 2'b10, 5'd0, 5'd3, 16'h0);
      strap = 3'd7;
      do_write(5'd7, 5'd5, 16'h0F0F);
      expect_read("R3 strap 7 matches", 5'd5, 16'h0F0F);
      strap = 3'd5;
   endtask

   task automatic t_opcode;
      expect_silent("R2 opcode 11 ignored", 32, 2'b01, 2'b11, 5'd5, 5'd3, 16'h0);
      expect_silent("R2 opcode 00 ignored", 32, 2'b01, 2'b00, 5'd5, 5'd3, 16'h2222);
      expect_read("R2 opcode 00 wrote nothing", 5'd3, 16'hA5C3);
   endtask

   task automatic t_preamble;
      logic [15:0] d;
      send_field(16'h0, 1);
      expect_silent("R1 31 ones rejected", 31, 2'b01, 2'b10, 5'd5, 5'd3, 16'h0);
      send_field(16'h0, 1);
      frame(40, 2'b01, 2'b10, 5'd5, 5'd3, 16'h0, d);
      check("R1 40 ones accepted", d, 16'hA5C3);
      expect_silent("R1 bad start pair", 32, 2'b00, 2'b10, 5'd5, 5'd3, 16'h0);
   endtask

   task automatic t_resync;
      logic [15:0] d;
      send_ones(32);
      send_field(16'h0, 2);
      expect_silent("R8 no preamble after bad start", 0, 2'b01, 2'b10, 5'd5, 5'd3, 16'h0);
      send_field(16'h0, 1);
      frame(32, 2'b01, 2'b11, 5'd5, 5'd3, 16'h0000, d);
      expect_silent("R8 no preamble after bad opcode", 0, 2'b01, 2'b10, 5'd5, 5'd3, 16'h0);
      expect_read("R8 fresh preamble recovers", 5'd3, 16'hA5C3);
   endtask

   initial begin
      repeat (3) @(negedge mdc);
      t_reset();
      t_write_read();
      t_boundary();
      t_address();
      t_opcode();
      t_preamble();
      t_resync();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule